// File: doc/BRIEF.md
# Pipelined Zero-Turnaround SRAM Controller

This block sits between a pipelined memory-mapped slave port and a synchronous SRAM that has no bus-turnaround penalty. It takes one read or one write command per clock and adds no wait states. Every pin that goes to the SRAM comes from a register: the word address, the active-low byte writes, the write and output strobes, and three chip enables of mixed polarity. Write data travels through a short pipeline and reaches the data bus in the late-write slot that the memory expects. Read data is captured from the bus and returned with a valid strobe, a fixed number of cycles after the read was accepted and in the order the reads were issued.

Read data and write data both reach the bus the same number of cycles after their command cycle. Because of this, reads and writes can alternate on every clock and the two directions never collide on the bus. A counter tracks the reads in flight. The slave port is stalled only when a new read arrives while that counter is at its configured ceiling. The data bus is given as separate output, output-enable and input vectors, and the pad-level tri-state is built from them at chip level.

Top module: `zbt_sram_ctrl`

## Requirements
- R1: In the cycle after a command is accepted, `m_addr` holds byte-address bits [22:2]. The two byte-offset bits are dropped.
- R2: In the cycle after an accepted write, `m_we_n`=0, `m_oe_n`=1 and `m_bw_n` is the bitwise inverse of `s_be`, where bit i covers data bits 8i+7..8i. In the cycle after an accepted read, `m_oe_n`=0, `m_we_n`=1 and `m_bw_n`=4'b1111.
- R3: `{m_ce1_n, m_ce2, m_ce3_n}` is 3'b010 only in the cycle after an accepted command. In every other cycle it is 3'b101, so the enables are not held through the read latency.
- R4: The write data appears on `m_dq_o` with `m_dq_oe`=1 exactly two cycles after the write is accepted. `m_dq_oe` is 0 in all other cycles.
- R5: `s_rvalid` is high exactly 3 cycles after each accepted read. `s_rdata` then carries the word the SRAM placed on `m_dq_i` in the cycle before, and returns keep the order in which the reads were issued.
- R6: Reads and writes can be accepted on consecutive cycles in any mix, with no idle cycle between them. Data stays consistent in program order: a read that follows a write to the same word returns the new data.
- R7: `s_wait` is high only when `s_read` is high and the number of reads accepted in earlier cycles whose valid has not yet reached or passed the current cycle equals MAX_PEND. A write is never stalled.
- R8: Synchronous reset drives every strobe and chip enable inactive and sets `m_dq_oe` and `s_rvalid` to 0. It clears the pending count and discards any reads in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the port and the SRAM |
| rst | input | 1 | Synchronous reset, active high |
| s_addr | input | 23 | Byte address |
| s_read | input | 1 | Read command |
| s_write | input | 1 | Write command; must not be high together with s_read |
| s_be | input | 4 | Byte enables for a write, active high |
| s_wdata | input | 32 | Write data |
| s_wait | output | 1 | Stall for a read presented while the in-flight limit is reached |
| s_rdata | output | 32 | Returned read data |
| s_rvalid | output | 1 | s_rdata valid this cycle |
| m_addr | output | 21 | SRAM word address |
| m_bw_n | output | 4 | SRAM byte writes, active low |
| m_we_n | output | 1 | SRAM write enable, active low |
| m_oe_n | output | 1 | SRAM output enable, active low |
| m_ce1_n | output | 1 | Chip enable, active low |
| m_ce2 | output | 1 | Chip enable, active high |
| m_ce3_n | output | 1 | Chip enable, active low |
| m_dq_o | output | 32 | Data driven toward the SRAM |
| m_dq_oe | output | 1 | Drive enable for m_dq_o; the pad is high impedance when 0 |
| m_dq_i | input | 32 | Data received from the SRAM |

## Verification
The bench builds the controller with its default widths and a 3-cycle read latency, but sets MAX_PEND to 2. With a fixed 3-cycle return, no more than three reads can ever be in flight, so the default limit of 64 can never stall. A limit of 2 puts the wait path within reach: a run of back-to-back reads stalls every third cycle, and a write issued while the limit is reached must still pass. Short address ranges make read-after-write and write-after-read to the same word frequent in the random mix. A reset taken with reads in flight shows that their returns are discarded.

// File: rtl/zbt_ctrl_pkg.sv
package zbt_ctrl_pkg;

  // Command accepted in the current cycle, as seen by every stage.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } zbt_op_e;

endpackage

// File: rtl/zbt_cmd_stage.sv
module zbt_cmd_stage
  import zbt_ctrl_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int BE_W   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  zbt_op_e                       op,
  input  logic [ADDR_W-1:0]             byte_addr,
  input  logic [BE_W-1:0]               be,
  output logic [ADDR_W-$clog2(BE_W)-1:0] m_addr,
  output logic [BE_W-1:0]               m_bw_n,
  output logic                          m_we_n,
  output logic                          m_oe_n,
  output logic                          m_ce1_n,
  output logic                          m_ce2,
  output logic                          m_ce3_n
);

  localparam int LSB = $clog2(BE_W);

  logic active;
  assign active = (op != OP_IDLE);

  // Every SRAM control pin leaves from a flop; enables last one cycle only.
  always_ff @(posedge clk) begin
    if (rst) begin
      m_addr  <= '0;
      m_bw_n  <= '1;
      m_we_n  <= 1'b1;
      m_oe_n  <= 1'b1;
      m_ce1_n <= 1'b1;
      m_ce2   <= 1'b0;
      m_ce3_n <= 1'b1;
    end else begin
      m_we_n  <= !(op == OP_WRITE);
      m_oe_n  <= !(op == OP_READ);
      m_bw_n  <= (op == OP_WRITE) ? ~be : '1;
      m_ce1_n <= !active;
      m_ce2   <= active;
      m_ce3_n <= !active;
      if (active) m_addr <= byte_addr[ADDR_W-1:LSB];
    end
  end

  AST_CE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) !m_ce1_n |-> $past(active)) else $error("enable without command"); // R3
  AST_ADDR_WORD: assert property (@(posedge clk) disable iff (rst) active |=> m_addr == $past(byte_addr[ADDR_W-1:LSB])) else $error("word address wrong"); // R1

endmodule

// File: rtl/zbt_data_pipe.sv
module zbt_data_pipe
  import zbt_ctrl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RD_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  zbt_op_e           op,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] dq_i,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  // Stages from acceptance to the bus slot; reads and writes share the slot.
  localparam int STG = RD_LAT - 1;

  logic [STG-1:0]    wv;
  logic [STG-1:0]    rv;
  logic [DATA_W-1:0] wd [STG];

  always_ff @(posedge clk) begin
    if (rst) begin
      wv <= '0;
      rv <= '0;
    end else begin
      wv[0] <= (op == OP_WRITE);
      rv[0] <= (op == OP_READ);
      for (int i = 1; i < STG; i++) begin
        wv[i] <= wv[i-1];
        rv[i] <= rv[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    wd[0] <= wdata;
    for (int i = 1; i < STG; i++) wd[i] <= wd[i-1];
  end

  assign dq_o  = wd[STG-1];
  assign dq_oe = wv[STG-1];

  // Capture the bus in the read slot, present it one cycle later.
  always_ff @(posedge clk) begin
    if (rst) rvalid <= 1'b0;
    else     rvalid <= rv[STG-1];
  end

  always_ff @(posedge clk) begin
    if (rv[STG-1]) rdata <= dq_i;
  end

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (rst) !(dq_oe && rv[STG-1])) else $error("bus driven in read slot"); // R6
  AST_WR_SLOT: assert property (@(posedge clk) disable iff (rst) dq_oe |-> $past(op == OP_WRITE, STG)) else $error("write data slot wrong"); // R4
  AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst) rvalid |-> $past(op == OP_READ, RD_LAT)) else $error("read return latency wrong"); // R5

endmodule

// File: rtl/zbt_pend_track.sv
module zbt_pend_track #(
  parameter int MAX_PEND = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req,
  input  logic rd_acc,
  input  logic rd_ret,
  output logic rd_wait
);

  localparam int CNT_W = $clog2(MAX_PEND + 1);

  logic [CNT_W-1:0] pend;
  logic [CNT_W-1:0] live;

  // A return in this cycle frees its slot for a read presented now.
  assign live    = pend - CNT_W'(rd_ret);
  assign rd_wait = rd_req && (live >= CNT_W'(MAX_PEND));

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend + CNT_W'(rd_acc) - CNT_W'(rd_ret);
  end

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (rst) pend <= CNT_W'(MAX_PEND)) else $error("pending count overflow"); // R7
  AST_RET_HAS_PEND: assert property (@(posedge clk) disable iff (rst) rd_ret |-> pend != '0) else $error("return with nothing pending"); // R8

endmodule

// File: rtl/zbt_sram_ctrl.sv
module zbt_sram_ctrl
  import zbt_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 23,
  parameter int DATA_W   = 32,
  parameter int RD_LAT   = 3,
  parameter int MAX_PEND = 64
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic [ADDR_W-1:0]                      s_addr,
  input  logic                                   s_read,
  input  logic                                   s_write,
  input  logic [DATA_W/8-1:0]                    s_be,
  input  logic [DATA_W-1:0]                      s_wdata,
  output logic                                   s_wait,
  output logic [DATA_W-1:0]                      s_rdata,
  output logic                                   s_rvalid,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]     m_addr,
  output logic [DATA_W/8-1:0]                    m_bw_n,
  output logic                                   m_we_n,
  output logic                                   m_oe_n,
  output logic                                   m_ce1_n,
  output logic                                   m_ce2,
  output logic                                   m_ce3_n,
  output logic [DATA_W-1:0]                      m_dq_o,
  output logic                                   m_dq_oe,
  input  logic [DATA_W-1:0]                      m_dq_i
);

  localparam int BE_W = DATA_W / 8;

  logic    rd_acc;
  zbt_op_e op;

  assign rd_acc = !rst && s_read && !s_write && !s_wait;

  always_comb begin
    if (rst)          op = OP_IDLE;
    else if (s_write) op = OP_WRITE;
    else if (rd_acc)  op = OP_READ;
    else              op = OP_IDLE;
  end

  zbt_pend_track #(.MAX_PEND(MAX_PEND)) i_pend (
    .clk    (clk),
    .rst    (rst),
    .rd_req (s_read),
    .rd_acc (rd_acc),
    .rd_ret (s_rvalid),
    .rd_wait(s_wait)
  );

  zbt_cmd_stage #(.ADDR_W(ADDR_W), .BE_W(BE_W)) i_cmd (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .byte_addr(s_addr),
    .be       (s_be),
    .m_addr   (m_addr),
    .m_bw_n   (m_bw_n),
    .m_we_n   (m_we_n),
    .m_oe_n   (m_oe_n),
    .m_ce1_n  (m_ce1_n),
    .m_ce2    (m_ce2),
    .m_ce3_n  (m_ce3_n)
  );

  zbt_data_pipe #(.DATA_W(DATA_W), .RD_LAT(RD_LAT)) i_data (
    .clk   (clk),
    .rst   (rst),
    .op    (op),
    .wdata (s_wdata),
    .dq_i  (m_dq_i),
    .dq_o  (m_dq_o),
    .dq_oe (m_dq_oe),
    .rdata (s_rdata),
    .rvalid(s_rvalid)
  );

  AST_ONE_CMD: assert property (@(posedge clk) disable iff (rst) !(s_read && s_write)) else $error("read and write together"); // R2
  AST_WRITE_NOT_STALLED: assert property (@(posedge clk) disable iff (rst) (s_write && !s_read) |-> !s_wait) else $error("write stalled"); // R7
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (m_we_n && m_oe_n && !m_dq_oe && !s_rvalid)) else $error("reset left strobes active"); // R8

endmodule

// File: tb/test_zbt_sram_ctrl.sv
module test_zbt_sram_ctrl;

  localparam int ADDR_W   = 23;
  localparam int DATA_W   = 32;
  localparam int BE_W     = 4;
  localparam int RD_LAT   = 3;
  localparam int MAX_PEND = 2;
  localparam int OPI = 0, OPR = 1, OPW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ADDR_W-1:0] s_addr = '0;
  logic s_read = 1'b0, s_write = 1'b0;
  logic [BE_W-1:0] s_be = '0;
  logic [DATA_W-1:0] s_wdata = '0;
  logic s_wait, s_rvalid;
  logic [DATA_W-1:0] s_rdata;
  logic [20:0] m_addr;
  logic [BE_W-1:0] m_bw_n;
  logic m_we_n, m_oe_n, m_ce1_n, m_ce2, m_ce3_n, m_dq_oe;
  logic [DATA_W-1:0] m_dq_o;
  logic [DATA_W-1:0] m_dq_i = '0;

  always #4 clk = ~clk;

  zbt_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_LAT(RD_LAT), .MAX_PEND(MAX_PEND)) i_zbt_sram_ctrl (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_read(s_read), .s_write(s_write),
    .s_be(s_be), .s_wdata(s_wdata), .s_wait(s_wait), .s_rdata(s_rdata), .s_rvalid(s_rvalid),
    .m_addr(m_addr), .m_bw_n(m_bw_n), .m_we_n(m_we_n), .m_oe_n(m_oe_n),
    .m_ce1_n(m_ce1_n), .m_ce2(m_ce2), .m_ce3_n(m_ce3_n),
    .m_dq_o(m_dq_o), .m_dq_oe(m_dq_oe), .m_dq_i(m_dq_i)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  function automatic logic [31:0] merge(logic [31:0] old, logic [31:0] nw, logic [3:0] be);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
    return r;
  endfunction

  function automatic logic [31:0] seed_word(int i);
    return 32'h9E3779B9 * (i + 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d actual=%h expected=%h", req, cyc, act, exp);
    end
  endtask

  // SRAM model: late write one cycle after its command, read data one cycle after its command.
  logic [31:0] dev_mem [256];
  logic dev_wp = 1'b0;
  logic [7:0] dev_wa;
  logic [3:0] dev_wbw;
  always @(posedge clk) begin
    if (dev_wp && m_dq_oe) dev_mem[dev_wa] = merge(dev_mem[dev_wa], m_dq_o, ~dev_wbw);
    dev_wp = 1'b0;
    if (!m_ce1_n && m_ce2 && !m_ce3_n) begin
      if (!m_we_n) begin dev_wp = 1'b1; dev_wa = m_addr[7:0]; dev_wbw = m_bw_n; end
      if (!m_oe_n) m_dq_i <= dev_mem[m_addr[7:0]];
    end
  end

  // Reference state
  logic [31:0] ref_mem [256];
  logic [31:0] q_data[$];
  int q_due[$];
  int p1_op = OPI, p2_op = OPI;
  logic [ADDR_W-1:0] p1_addr;
  logic [3:0] p1_be;
  logic [31:0] p1_wd, p2_wd;

  task automatic cycle(input bit rd, input bit wr, input logic [ADDR_W-1:0] a,
                       input logic [3:0] be, input logic [31:0] wd, output bit acc);
    int ahead;
    bit exp_wait, exp_rv;
    @(negedge clk);
    s_read = rd; s_write = wr; s_addr = a; s_be = be; s_wdata = wd;
    #1;
    ahead = 0;
    foreach (q_due[k]) if (q_due[k] > cyc) ahead++;
    exp_wait = rd && (ahead >= MAX_PEND);
    chk(s_wait == exp_wait, "R7", 64'(s_wait), 64'(exp_wait));
    exp_rv = (q_due.size() > 0) && (q_due[0] == cyc);
    chk(s_rvalid == exp_rv, "R5", 64'(s_rvalid), 64'(exp_rv));
    if (exp_rv) begin
      chk(s_rdata == q_data[0], "R5", 64'(s_rdata), 64'(q_data[0]));
      void'(q_data.pop_front());
      void'(q_due.pop_front());
    end
    chk({m_ce1_n, m_ce2, m_ce3_n} == ((p1_op != OPI) ? 3'b010 : 3'b101), "R3",
        64'({m_ce1_n, m_ce2, m_ce3_n}), 64'((p1_op != OPI) ? 3'b010 : 3'b101));
    chk(m_we_n == (p1_op != OPW), "R2", 64'(m_we_n), 64'(p1_op != OPW));
    chk(m_oe_n == (p1_op != OPR), "R2", 64'(m_oe_n), 64'(p1_op != OPR));
    chk(m_bw_n == ((p1_op == OPW) ? ~p1_be : 4'hF), "R2", 64'(m_bw_n), 64'((p1_op == OPW) ? ~p1_be : 4'hF));
    if (p1_op != OPI) chk(m_addr == p1_addr[22:2], "R1", 64'(m_addr), 64'(p1_addr[22:2]));
    chk(m_dq_oe == (p2_op == OPW), "R4", 64'(m_dq_oe), 64'(p2_op == OPW));
    if (p2_op == OPW) chk(m_dq_o == p2_wd, "R4", 64'(m_dq_o), 64'(p2_wd));
    acc = wr || (rd && !exp_wait);
    p2_op = p1_op; p2_wd = p1_wd;
    p1_op = !acc ? OPI : (wr ? OPW : OPR);
    p1_addr = a; p1_be = be; p1_wd = wd;
    if (acc && wr) ref_mem[a[9:2]] = merge(ref_mem[a[9:2]], wd, be);
    if (acc && rd && !wr) begin
      q_data.push_back(ref_mem[a[9:2]]);
      q_due.push_back(cyc + RD_LAT);
    end
    cyc++;
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cycle(1'b0, 1'b0, '0, '0, '0, acc);
  endtask

  task automatic rd_hold(input logic [ADDR_W-1:0] a);
    bit acc;
    do cycle(1'b1, 1'b0, a, 4'h0, '0, acc); while (!acc);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; s_read = 1'b0; s_write = 1'b0;
    repeat (2) @(negedge clk);
    #1;
    // R8: reset state visible at the ports
    chk({m_we_n, m_oe_n, m_bw_n} == 6'h3F, "R8", 64'({m_we_n, m_oe_n, m_bw_n}), 64'h3F);
    chk({m_ce1_n, m_ce2, m_ce3_n} == 3'b101, "R8", 64'({m_ce1_n, m_ce2, m_ce3_n}), 64'b101);
    chk({m_dq_oe, s_rvalid} == 2'b00, "R8", 64'({m_dq_oe, s_rvalid}), 64'h0);
    rst = 1'b0;
    q_data.delete(); q_due.delete();
    p1_op = OPI; p2_op = OPI;
    cyc += 3;
  endtask

  initial begin
    #(64'd8 * 64'd200000);
    checks++; errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit acc;
    int n_acc;
    bit h_rd, h_wr;
    logic [ADDR_W-1:0] h_a;
    logic [3:0] h_be;
    logic [31:0] h_wd;
    void'($urandom(32'd7411));
    for (int i = 0; i < 256; i++) begin dev_mem[i] = seed_word(i); ref_mem[i] = seed_word(i); end
    do_reset();

    // R6: write then read of the same word on the next clock, low offset bits ignored (R1)
    cycle(1'b0, 1'b1, 23'h12_3457, 4'hF, 32'hCAFE_0001, acc);
    rd_hold(23'h12_3454);
    idle(4);
    // read then write of the same word: read sees old data
    rd_hold(23'h00_0040);
    cycle(1'b0, 1'b1, 23'h00_0040, 4'hF, 32'h1111_2222, acc);
    rd_hold(23'h00_0043);
    idle(4);
    // R2: partial byte write
    cycle(1'b0, 1'b1, 23'h7F_FF08, 4'b0101, 32'hAABB_CCDD, acc);
    rd_hold(23'h7F_FF08);
    idle(4);
    // R7: read run hits the limit; a write in the full cycle is not stalled
    rd_hold(23'h10);
    rd_hold(23'h14);
    cycle(1'b0, 1'b1, 23'h18, 4'hF, 32'h5555_AAAA, acc);
    chk(acc == 1'b1, "R7", 64'(acc), 64'h1);
    for (int i = 0; i < 6; i++) rd_hold(23'(32'h18 + 4 * i));
    idle(4);
    // R6: alternating writes and reads, one accepted per clock
    n_acc = 0;
    for (int i = 0; i < 10; i++) begin
      if (i[0]) cycle(1'b1, 1'b0, 23'(32'h200 + 4 * i), 4'h0, '0, acc);
      else      cycle(1'b0, 1'b1, 23'(32'h204 + 4 * i), 4'hF, 32'(32'hD000_0000 + i), acc);
      n_acc += int'(acc);
    end
    chk(n_acc == 10, "R6", 64'(n_acc), 64'd10);
    idle(4);

    // random mix with hold on stall
    h_rd = 1'b0; h_wr = 1'b0; h_a = '0; h_be = '0; h_wd = '0;
    for (int i = 0; i < 3000; i++) begin
      if (!(h_rd && !acc)) begin
        int r;
        r = int'($urandom % 8);
        h_rd = (r < 3);
        h_wr = (r >= 3 && r < 6);
        h_a = {11'($urandom), 6'($urandom), 2'b00, 2'($urandom)} ^ {ADDR_W{1'b0}};
        h_a[9:4] = 6'($urandom);
        h_be = 4'($urandom);
        h_wd = $urandom;
      end
      cycle(h_rd, h_wr, h_a, h_be, h_wd, acc);
    end
    idle(4);

    // R8: reset with reads in flight discards their returns
    rd_hold(23'h300);
    rd_hold(23'h304);
    do_reset();
    idle(5);
    rd_hold(23'h300);
    idle(4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule